// File: doc/BRIEF.md
# DMA Channel Pause-Resume Controller

This block holds the control state of a single DMA channel: the enable bit, the programmed count, peripheral address, memory address and mode, and the working copies of count and addresses that advance while the channel runs. The datapath reports each finished beat on `beat_done`. The controller decrements the working count and steps the addresses. It reports whether the channel is enabled, whether beats are still owed, and whether the transfer has completed.

Software can clear the enable bit at any point in a transfer. When it sets the bit again, the block decides between two outcomes. If no setting was written while the channel was off, the transfer continues from where it stopped. If any setting was written, the working values are reloaded from the programmed ones and a new transfer begins. A transfer that had already finished stays finished when the channel is re-enabled without a new setting. A fresh start with a zero count moves nothing.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, `active`, `busy` and `done` are 0 and the working count and both working addresses read 0.
- R2: A write with `wr_sel`=0 loads `wr_data[0]` into the enable bit, and `active` shows the enable bit. While the enable bit is 0, `beat_done` leaves the count and addresses unchanged.
- R3: Setting writes use these select codes: `wr_sel`=1 count, 2 peripheral address, 3 memory address, 4 mode. A setting write is stored only while the enable bit is 0. Made while enabled, it is ignored and does not mark the settings as changed.
- R4: A stored setting write marks the settings as changed, and this mark is also set by reset. An enable (0 to 1) with the mark set copies count, addresses and mode into the working registers, clears `done` and clears the mark.
- R5: An enable without the mark keeps the working count, addresses and mode, so the remaining beats continue.
- R6: A `beat_done` is accepted only while `busy` is 1, and each accepted beat lowers the working count by exactly one.
- R7: The mode field uses bit 0 for peripheral-address increment and bit 1 for memory-address increment. Bits 3:2 give the step: 0 gives 1, 1 gives 2, and 2 or 3 give 4. On an accepted beat, each address whose increment bit is set advances by the step. The other address holds.
- R8: `done` becomes 1 when an accepted beat brings the count to zero. It stays 1 until a fresh start. Re-enabling a finished channel without a setting write leaves `busy` at 0.
- R9: A fresh start with a programmed count of 0 leaves `busy` at 0 and `done` at 0. Later `beat_done` pulses change nothing.
- R10: `busy` is 1 exactly when the channel is enabled and the working count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 control, 1 count, 2 peripheral address, 3 memory address, 4 mode) |
| wr_data | input | DATA_W | Write data |
| beat_done | input | 1 | One beat finished by the datapath |
| active | output | 1 | Enable bit |
| busy | output | 1 | Enabled with beats outstanding |
| done | output | 1 | Sticky completion flag |
| cur_count | output | CNT_W | Working count |
| cur_paddr | output | ADDR_W | Working peripheral address |
| cur_maddr | output | ADDR_W | Working memory address |

## Verification
The assertions assume that the write port carries at most one register write per cycle. They also assume that `beat_done` is sampled from the channel's own state, so a beat that arrives while `busy` is low is dropped rather than queued. The stimulus drives every input just after the falling clock edge and pulses `beat_done` both while `busy` is high and while it is low. Select codes outside 0 to 4 are never driven. Only the mode patterns listed in R7 are driven, so every address step the assertions expect is one of 1, 2 or 4.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_COUNT = 3'd1,
    SEL_PADDR = 3'd2,
    SEL_MADDR = 3'd3,
    SEL_MODE  = 3'd4
  } reg_sel_e;

  // bits [3:2] step size, [1] memory increment, [0] peripheral increment
  typedef struct packed {
    logic [1:0] size;
    logic       m_inc;
    logic       p_inc;
  } chan_mode_t;

  localparam int MODE_W = $bits(chan_mode_t);

  function automatic logic [2:0] step_of(input logic [1:0] size);
    case (size)
      2'd0:    step_of = 3'd1;
      2'd1:    step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en_o,
  output logic              start_o,
  output logic              fresh_o,
  output logic [CNT_W-1:0]  prog_cnt_o,
  output logic [ADDR_W-1:0] prog_paddr_o,
  output logic [ADDR_W-1:0] prog_maddr_o,
  output chan_mode_t        prog_mode_o
);

  logic              en_q, en_d;
  logic              dirty_q, dirty_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] pa_q, ma_q;
  chan_mode_t        mode_q;

  logic ctrl_wr, cfg_wr, start, fresh;
  logic cnt_we, pa_we, ma_we, mode_we;

  always_comb begin
    ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    cfg_wr  = wr_en && !en_q && (wr_sel >= SEL_COUNT) && (wr_sel <= SEL_MODE);
    start   = ctrl_wr && wr_data[0] && !en_q;
    fresh   = start && dirty_q;
    cnt_we  = cfg_wr && (wr_sel == SEL_COUNT);
    pa_we   = cfg_wr && (wr_sel == SEL_PADDR);
    ma_we   = cfg_wr && (wr_sel == SEL_MADDR);
    mode_we = cfg_wr && (wr_sel == SEL_MODE);
    en_d    = ctrl_wr ? wr_data[0] : en_q;
    if (start)       dirty_d = 1'b0;
    else if (cfg_wr) dirty_d = 1'b1;
    else             dirty_d = dirty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      dirty_q <= 1'b1;
    end else begin
      en_q    <= en_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pa_q <= '0;
    else if (pa_we) pa_q <= wr_data[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ma_q <= '0;
    else if (ma_we) ma_q <= wr_data[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= chan_mode_t'(wr_data[MODE_W-1:0]);
  end

  assign en_o         = en_q;
  assign start_o      = start;
  assign fresh_o      = fresh;
  assign prog_cnt_o   = cnt_q;
  assign prog_paddr_o = pa_q;
  assign prog_maddr_o = ma_q;
  assign prog_mode_o  = mode_q;

  // R3: settings are frozen while the channel is enabled
  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(cnt_q) && $stable(pa_q) && $stable(ma_q) && $stable(mode_q)));

  // R4: an enable always consumes the change mark
  p_dirty_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!dirty_q && en_q));

endmodule

// File: rtl/dma_addr_walk.sv
module dma_addr_walk #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic              inc_en,
  input  logic [2:0]        step,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_we;

  always_comb begin
    addr_we = load || (adv && inc_en);
    addr_d  = load ? load_val : (addr_q + ADDR_W'(step));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_we) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R7: an address moves only on a load or an accepted beat
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(addr_q));

endmodule

// File: rtl/dma_xfer_state.sv
module dma_xfer_state
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fresh,
  input  logic             beat_done,
  input  logic [CNT_W-1:0] prog_cnt,
  input  chan_mode_t       prog_mode,
  output logic             busy_o,
  output logic             accept_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o,
  output chan_mode_t       mode_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  chan_mode_t       mode_q;
  logic             busy, accept, cnt_we, last_beat;

  always_comb begin
    busy      = en && (cnt_q != '0);
    accept    = beat_done && busy;
    last_beat = accept && (cnt_q == CNT_W'(1));
    cnt_we    = fresh || accept;
    cnt_d     = fresh ? prog_cnt : (cnt_q - CNT_W'(1));
    if (fresh)          done_d = 1'b0;
    else if (last_beat) done_d = 1'b1;
    else                done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (fresh) mode_q <= prog_mode;
  end

  assign busy_o   = busy;
  assign accept_o = accept;
  assign done_o   = done_q;
  assign cnt_o    = cnt_q;
  assign mode_o   = mode_q;

  // R6: one accepted beat, one count
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R2: nothing moves while disabled
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !fresh) |=> $stable(cnt_q));

  // R8: completion sticks until a fresh start
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !fresh) |=> done_q);

  // R9: a zero-count start owes no beats
  p_zero_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && (prog_cnt == '0)) |=> (!busy && !done_q));

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              beat_done,
  output logic              active,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  cur_count,
  output logic [ADDR_W-1:0] cur_paddr,
  output logic [ADDR_W-1:0] cur_maddr
);

  localparam int N_PTR = 2;  // 0 peripheral, 1 memory

  logic                         en, start, fresh, accept;
  logic [CNT_W-1:0]             prog_cnt;
  logic [N_PTR-1:0][ADDR_W-1:0] prog_addr, cur_addr;
  logic [N_PTR-1:0]             inc_en;
  chan_mode_t                   prog_mode, work_mode;
  logic [2:0]                   step;

  dma_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .en_o         (en),
    .start_o      (start),
    .fresh_o      (fresh),
    .prog_cnt_o   (prog_cnt),
    .prog_paddr_o (prog_addr[0]),
    .prog_maddr_o (prog_addr[1]),
    .prog_mode_o  (prog_mode)
  );

  dma_xfer_state #(.CNT_W(CNT_W)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .fresh     (fresh),
    .beat_done (beat_done),
    .prog_cnt  (prog_cnt),
    .prog_mode (prog_mode),
    .busy_o    (busy),
    .accept_o  (accept),
    .done_o    (done),
    .cnt_o     (cur_count),
    .mode_o    (work_mode)
  );

  assign step   = step_of(work_mode.size);
  assign inc_en = {work_mode.m_inc, work_mode.p_inc};

  for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
    dma_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fresh),
      .load_val (prog_addr[i]),
      .adv      (accept),
      .inc_en   (inc_en[i]),
      .step     (step),
      .addr_o   (cur_addr[i])
    );
  end

  assign active    = en;
  assign cur_paddr = cur_addr[0];
  assign cur_maddr = cur_addr[1];

  // R10: beats are owed only by an enabled channel
  p_busy_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> active);

  // R5: a resume leaves the working values where they were
  p_resume_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !fresh) |=> ($stable(cur_count) && $stable(cur_paddr) && $stable(cur_maddr)));

  // R8: completion comes only from the last accepted beat
  p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cur_count == '0));

endmodule

// File: tb/tb_dma_chan_ctl.sv
module tb_dma_chan_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, beat_done;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic        active, busy, done;
  logic [15:0] cur_count, cur_paddr, cur_maddr;

  int checks = 0;
  int errors = 0;
  bit run_cmp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .beat_done(beat_done), .active(active), .busy(busy), .done(done),
    .cur_count(cur_count), .cur_paddr(cur_paddr), .cur_maddr(cur_maddr)
  );

  // behavioural reference
  bit          m_en, m_dirty, m_done;
  logic [15:0] p_cnt, p_pa, p_ma, w_cnt, w_pa, w_ma;
  logic [3:0]  p_mode, w_mode;

  always @(posedge clk or negedge rst_n) begin : ref_model
    int st;
    bit acc;
    if (!rst_n) begin
      m_en = 0; m_dirty = 1; m_done = 0;
      p_cnt = 0; p_pa = 0; p_ma = 0; p_mode = 0;
      w_cnt = 0; w_pa = 0; w_ma = 0; w_mode = 0;
    end else begin
      acc = beat_done && m_en && (w_cnt != 0);
      if (acc) begin
        st = (w_mode[3:2] == 0) ? 1 : (w_mode[3:2] == 1) ? 2 : 4;
        w_cnt = w_cnt - 1;
        if (w_mode[0]) w_pa = w_pa + 16'(st);
        if (w_mode[1]) w_ma = w_ma + 16'(st);
        if (w_cnt == 0) m_done = 1;
      end
      if (wr_en) begin
        if (wr_sel == 0) begin
          if (wr_data[0] && !m_en) begin
            if (m_dirty) begin
              w_cnt = p_cnt; w_pa = p_pa; w_ma = p_ma; w_mode = p_mode; m_done = 0;
            end
            m_dirty = 0;
          end
          m_en = wr_data[0];
        end else if (!m_en && wr_sel <= 4) begin
          m_dirty = 1;
          case (wr_sel)
            1: p_cnt = wr_data;
            2: p_pa = wr_data;
            3: p_ma = wr_data;
            default: p_mode = wr_data[3:0];
          endcase
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (run_cmp) begin
      chk("R2 active", 32'(active), 32'(m_en));
      chk("R10 busy", 32'(busy), 32'(m_en && (w_cnt != 0)));
      chk("R8 done", 32'(done), 32'(m_done));
      chk("R6 count", 32'(cur_count), 32'(w_cnt));
      chk("R7 paddr", 32'(cur_paddr), 32'(w_pa));
      chk("R7 maddr", 32'(cur_maddr), 32'(w_ma));
    end
  end

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic beats(input int n);
    beat_done = 1'b1;
    repeat (n) @(negedge clk);
    beat_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; beat_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 active", 32'(active), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 count", 32'(cur_count), 0);
    chk("R1 addr", 32'({cur_paddr, cur_maddr}), 0);
    run_cmp = 1'b1;

    // fresh transfer, word steps, both increments
    wr(1, 16'd4); wr(2, 16'h0100); wr(3, 16'h2000); wr(4, 16'h000B);
    wr(0, 16'd1);
    chk("R4 load count", 32'(cur_count), 4);
    chk("R10 busy on start", 32'(busy), 1);
    beats(2);
    chk("R6 count after 2", 32'(cur_count), 2);
    chk("R7 paddr word step", 32'(cur_paddr), 32'h0108);
    chk("R7 maddr word step", 32'(cur_maddr), 32'h2008);

    // pause, beats ignored
    wr(0, 16'd0);
    beats(2);
    chk("R2 count held when off", 32'(cur_count), 2);
    chk("R2 paddr held when off", 32'(cur_paddr), 32'h0108);

    // resume
    wr(0, 16'd1);
    chk("R5 resume count", 32'(cur_count), 2);
    chk("R5 resume maddr", 32'(cur_maddr), 32'h2008);

    // write while enabled is ignored; finish
    wr(1, 16'd9);
    beats(3);
    chk("R8 done at zero", 32'(done), 1);
    chk("R10 busy at zero", 32'(busy), 0);

    // resume a finished transfer
    wr(0, 16'd0); wr(0, 16'd1);
    chk("R8 no relaunch", 32'(busy), 0);
    chk("R8 done sticky", 32'(done), 1);

    // restart after a setting write, count was not changed by R3 ignore
    wr(0, 16'd0); wr(2, 16'h0040); wr(0, 16'd1);
    chk("R3 enabled write ignored", 32'(cur_count), 4);
    chk("R4 done cleared", 32'(done), 0);
    chk("R4 paddr reloaded", 32'(cur_paddr), 32'h0040);

    // half-word step, memory increment off
    wr(0, 16'd0); wr(4, 16'h0005); wr(0, 16'd1);
    beats(1);
    chk("R7 paddr half step", 32'(cur_paddr), 32'h0042);
    chk("R7 maddr held", 32'(cur_maddr), 32'h2000);

    // zero-count start
    wr(0, 16'd0); wr(1, 16'd0); wr(0, 16'd1);
    chk("R9 zero busy", 32'(busy), 0);
    chk("R9 zero done", 32'(done), 0);
    beats(2);
    chk("R9 zero count stays", 32'(cur_count), 0);

    // byte step, both increments with size code 3 giving 4 on memory
    wr(0, 16'd0); wr(1, 16'd3); wr(4, 16'h0001); wr(0, 16'd1);
    beats(1);
    chk("R7 byte step", 32'(cur_paddr), 32'h0041);
    wr(0, 16'd0); wr(4, 16'h000E); wr(0, 16'd1);
    beats(1);
    chk("R7 size3 step", 32'(cur_maddr), 32'h2004);
    chk("R6 count after one", 32'(cur_count), 2);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule